// File: doc/BRIEF.md
# Posted Write Buffer with Deferred Error Reporting

This block lets an in-order core retire stores without waiting for the memory bus. Each accepted store goes into a small in-order queue. A single issuer drains the queue onto a bus write channel, one write at a time. Because the core has already moved on, a bus error on one of these writes is reported later as an imprecise access-error exception. The exception carries the program counter the core presents when the error arrives, not the address of the store that faulted.

A barrier request lets software collect those errors. The barrier is not acknowledged until the queue is empty and no bus write is still open. The error latch is updated on the same edge that closes the last write, so any pending fault is already visible on the exception output when the barrier acknowledge rises. Software places the barrier after a group of stores and reads the exception output once the acknowledge arrives.

Top module: `wpb_unit`

## Requirements
- R1: Out of reset, st_ready is 1 and bus_req, exc_valid and bar_ack are all 0.
- R2: A store is accepted on a clock edge where st_valid and st_ready are both 1, without waiting for any bus write to finish. st_ready is 0 exactly while DEPTH (default 4) stores are queued behind the write on the bus. With one long bus write open, five stores are accepted before st_ready falls.
- R3: Bus writes carry the accepted address and data and are issued strictly in acceptance order.
- R4: At most one bus write is open at a time. bus_req stays 1, with bus_addr and bus_data stable, until a cycle where bus_done is 1.
- R5: A write that completes with bus_done=1 and bus_err=1 sets exc_valid in the next cycle. exc_pc then equals core_pc from the completion cycle.
- R6: Only the first error is kept. Later errors leave exc_valid and exc_pc unchanged until exc_ack. exc_ack clears exc_valid in the next cycle, and an error completing in that same cycle is dropped.
- R7: bar_ack is a one-cycle pulse. It rises in the cycle after bar_req is high, the queue is empty, no bus write is open and no store is being accepted. With nothing pending, it therefore arrives one cycle after bar_req rises.
- R8: When bar_ack rises, exc_valid is already 1 if any write before the barrier ended in error and the error has not been acknowledged.
- R9: bus_err without bus_done, and bus_done or bus_err while no bus write is open, have no effect on exc_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| bar_req | input | 1 | Barrier request, held until acknowledged |
| bar_ack | output | 1 | Barrier complete pulse |
| core_pc | input | PW | Program counter currently presented by the core |
| bus_req | output | 1 | Bus write open |
| bus_addr | output | AW | Bus write address |
| bus_data | output | DW | Bus write data |
| bus_done | input | 1 | Bus write completes this cycle |
| bus_err | input | 1 | With bus_done: write failed |
| exc_valid | output | 1 | Access-error exception pending |
| exc_pc | output | PW | Program counter captured with the error |
| exc_ack | input | 1 | Core has taken the exception |

## Verification
The hardest case to reach is a full queue: four stores waiting behind one open write. The bench reaches it by giving the first write a latency of 40 cycles while it offers stores back to back, and it counts how many are accepted before st_ready falls. For deferred errors, a bench bus model that also drives core_pc fails chosen writes from a vector table. It records the program counter of the first failure, and the bench checks that value when the barrier completes. A noise mode drives the bus error and done lines outside valid completions.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  typedef enum logic {ISS_IDLE = 1'b0, ISS_BUSY = 1'b1} iss_state_t;

  // Next position in a ring of 'depth' slots.
  function automatic logic [31:0] wpb_wrap_inc(input logic [31:0] p, input logic [31:0] depth);
    return (p + 32'd1 == depth) ? 32'd0 : p + 32'd1;
  endfunction

  // Occupancy after one cycle of push/pop.
  function automatic logic [31:0] wpb_level_next(input logic [31:0] lvl, input logic push,
                                                 input logic pop);
    return lvl + {31'd0, push} - {31'd0, pop};
  endfunction

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo
  import wpb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;

  assign empty    = (level == '0);
  assign full     = (level == LVL_W'(DEPTH));
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wpb_wrap_inc(32'(wr_ptr), 32'(DEPTH)));
      if (pop)  rd_ptr <= PTR_W'(wpb_wrap_inc(32'(rd_ptr), 32'(DEPTH)));
      level <= LVL_W'(wpb_level_next(32'(level), push, pop));
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R3

endmodule

// File: rtl/wpb_issuer.sv
module wpb_issuer
  import wpb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic [AW+DW-1:0] q_head,
  output logic          q_pop,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic          wr_err_evt,
  output logic          idle
);
  iss_state_t state;

  assign idle       = (state == ISS_IDLE);
  assign q_pop      = idle && !q_empty;
  assign bus_req    = (state == ISS_BUSY);
  assign wr_err_evt = bus_req && bus_done && bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ISS_IDLE;
      bus_addr <= '0;
      bus_data <= '0;
    end else if (q_pop) begin
      {bus_addr, bus_data} <= q_head;
      state                <= ISS_BUSY;
    end else if (bus_req && bus_done) begin
      state <= ISS_IDLE;
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_data));  // R4
  AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> !q_pop);  // R4

endmodule

// File: rtl/wpb_err_latch.sv
module wpb_err_latch #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt,
  input  logic [PW-1:0] core_pc,
  input  logic          exc_ack,
  output logic          exc_valid,
  output logic [PW-1:0] exc_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_pc    <= '0;
    end else if (exc_ack) begin
      exc_valid <= 1'b0;
    end else if (err_evt && !exc_valid) begin
      exc_valid <= 1'b1;
      exc_pc    <= core_pc;
    end
  end

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && !exc_valid && !exc_ack |=> exc_valid && exc_pc == $past(core_pc));  // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_ack |=> exc_valid && $stable(exc_pc));  // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ack |=> !exc_valid);  // R6

endmodule

// File: rtl/wpb_unit.sv
module wpb_unit #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          bar_req,
  output logic          bar_ack,
  input  logic [PW-1:0] core_pc,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic          exc_valid,
  output logic [PW-1:0] exc_pc,
  input  logic          exc_ack
);
  localparam int EW = AW + DW;

  logic          q_push, q_pop, q_empty, q_full;
  logic [EW-1:0] q_head;
  logic          wr_err_evt, iss_idle, drained;

  assign st_ready = !q_full;
  assign q_push   = st_valid && st_ready;

  wpb_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data({st_addr, st_data}),
    .pop(q_pop), .pop_data(q_head), .empty(q_empty), .full(q_full)
  );

  wpb_issuer #(.AW(AW), .DW(DW)) u_issuer (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_done(bus_done), .bus_err(bus_err), .wr_err_evt(wr_err_evt), .idle(iss_idle)
  );

  wpb_err_latch #(.PW(PW)) u_err (
    .clk(clk), .rst_n(rst_n), .err_evt(wr_err_evt), .core_pc(core_pc),
    .exc_ack(exc_ack), .exc_valid(exc_valid), .exc_pc(exc_pc)
  );

  // Barrier completes once nothing is queued, open or entering.
  assign drained = q_empty && iss_idle && !q_push;

  always_ff @(posedge clk) begin
    if (!rst_n) bar_ack <= 1'b0;
    else        bar_ack <= bar_req && drained && !bar_ack;
  end

  AST_BAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_ack |=> !bar_ack);  // R7
  AST_BAR_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    bar_ack |-> !bus_req);  // R7
  AST_BAR_ERR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_evt && !exc_ack |=> exc_valid);  // R8

endmodule

// File: tb/test_wpb_unit.sv
module test_wpb_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, st_valid, st_ready, bar_req, bar_ack, bus_req, bus_done, bus_err;
  logic        exc_valid, exc_ack;
  logic [31:0] st_addr, st_data, core_pc, bus_addr, bus_data, exc_pc;

  wpb_unit i_wpb_unit (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .bar_req(bar_req), .bar_ack(bar_ack),
    .core_pc(core_pc), .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_done(bus_done), .bus_err(bus_err), .exc_valid(exc_valid), .exc_pc(exc_pc),
    .exc_ack(exc_ack)
  );

  int tests = 0, fails = 0;
  logic [31:0] exp_addr [16], exp_data [16];
  int          exp_lat [16];
  logic        exp_fault [16];
  int          n_exp = 0, wr_idx = 0, wcnt = 0;
  logic        first_err_seen = 1'b0, noise = 1'b0;
  logic [31:0] first_err_pc = '0;

  // vector table: {addr, data, latency, fault}
  localparam int NV = 8;
  localparam logic [31:0] T_ADDR [NV] = '{32'h100, 32'h104, 32'h2000, 32'h108,
                                          32'h3000, 32'h4004, 32'h10C, 32'hFFFC};
  localparam logic [31:0] T_DATA [NV] = '{32'hA5A5_0001, 32'h0000_0000, 32'hDEAD_BEEF, 32'hFFFF_FFFF,
                                          32'h1234_5678, 32'h0BAD_F00D, 32'h5A5A_5A5A, 32'h8000_0001};
  localparam int          T_LAT  [NV] = '{1, 3, 2, 1, 5, 1, 2, 4};
  localparam logic        T_FLT  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus responder and program counter source
  initial begin
    bus_done = 1'b0; bus_err = 1'b0; core_pc = 32'h8000;
    forever begin
      @(negedge clk);
      core_pc = core_pc + 32'd4;
      if (bus_done) begin
        bus_done = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_req) begin
        wcnt++;
        if (wr_idx >= n_exp) begin
          chk(1'b0, "R3 unexpected write", bus_addr, 32'h0);
          bus_done = 1'b1; bus_err = 1'b0;
        end else if (wcnt >= exp_lat[wr_idx]) begin
          chk(bus_addr == exp_addr[wr_idx], "R3 order addr", bus_addr, exp_addr[wr_idx]);
          chk(bus_data == exp_data[wr_idx], "R3 order data", bus_data, exp_data[wr_idx]);
          bus_done = 1'b1;
          bus_err  = exp_fault[wr_idx];
          if (exp_fault[wr_idx] && !first_err_seen) begin
            first_err_seen = 1'b1; first_err_pc = core_pc;
          end
          wr_idx++;
        end else begin
          bus_err = noise;
        end
      end else begin
        bus_done = noise; bus_err = noise;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic push_store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic barrier(output int cyc);
    @(negedge clk);
    bar_req = 1'b1; cyc = 0;
    while (!bar_ack) begin @(negedge clk); cyc++; end
  endtask

  task automatic barrier_end();
    bar_req = 1'b0;
    @(negedge clk);
    chk(bar_ack == 1'b0, "R7 ack pulse", 32'(bar_ack), 32'h0);
  endtask

  task automatic ack_exc();
    @(negedge clk); exc_ack = 1'b1;
    @(negedge clk); exc_ack = 1'b0;
    chk(exc_valid == 1'b0, "R6 ack clears", 32'(exc_valid), 32'h0);
  endtask

  task automatic new_run();
    wr_idx = 0; n_exp = 0; first_err_seen = 1'b0;
  endtask

  initial begin
    int cyc, accepted;
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    bar_req = 1'b0; exc_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 32'h1);
    chk(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 32'h0);
    chk(exc_valid == 1'b0, "R1 exc_valid", 32'(exc_valid), 32'h0);
    chk(bar_ack == 1'b0, "R1 bar_ack", 32'(bar_ack), 32'h0);
    rst_n = 1'b1;

    // R7 barrier with nothing pending: ack one cycle later
    barrier(cyc);
    chk(cyc == 1, "R7 empty barrier latency", 32'(cyc), 32'h1);
    barrier_end();

    // table walk: order (R3), first error only (R6), error seen at barrier (R8)
    new_run();
    for (int i = 0; i < NV; i++) begin
      exp_addr[i] = T_ADDR[i]; exp_data[i] = T_DATA[i];
      exp_lat[i] = T_LAT[i]; exp_fault[i] = T_FLT[i];
    end
    n_exp = NV;
    for (int i = 0; i < NV; i++) push_store(T_ADDR[i], T_DATA[i]);
    barrier(cyc);
    chk(wr_idx == NV, "R7 barrier after all writes", 32'(wr_idx), 32'(NV));
    chk(exc_valid == 1'b1, "R8 error visible at barrier", 32'(exc_valid), 32'h1);
    chk(exc_pc == first_err_pc, "R6 first error pc kept", exc_pc, first_err_pc);
    barrier_end();
    ack_exc();

    // R2 fill: long first write, stores offered back to back
    new_run();
    for (int i = 0; i < 8; i++) begin
      exp_addr[i] = 32'h5000 + 32'(i * 4); exp_data[i] = 32'hC0DE_0000 + 32'(i);
      exp_lat[i] = (i == 0) ? 40 : 1; exp_fault[i] = 1'b0;
    end
    n_exp = 5;
    accepted = 0;
    @(negedge clk);
    st_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      st_addr = 32'h5000 + 32'(accepted * 4);
      st_data = 32'hC0DE_0000 + 32'(accepted);
      if (st_ready) accepted++;
      @(negedge clk);
    end
    st_valid = 1'b0;
    chk(accepted == 5, "R2 stores accepted while write open", 32'(accepted), 32'h5);
    chk(st_ready == 1'b0, "R2 ready low when full", 32'(st_ready), 32'h0);
    chk(bus_req == 1'b1, "R4 first write still open", 32'(bus_req), 32'h1);
    barrier(cyc);
    chk(wr_idx == 5, "R3 all five written", 32'(wr_idx), 32'h5);
    chk(st_ready == 1'b1, "R2 ready after drain", 32'(st_ready), 32'h1);
    chk(exc_valid == 1'b0, "R5 no error without fault", 32'(exc_valid), 32'h0);
    barrier_end();

    // R5 single faulting store: pc captured at completion
    new_run();
    exp_addr[0] = 32'h7770; exp_data[0] = 32'h1111_2222; exp_lat[0] = 3; exp_fault[0] = 1'b1;
    n_exp = 1;
    push_store(32'h7770, 32'h1111_2222);
    barrier(cyc);
    chk(exc_valid == 1'b1, "R5 exc raised", 32'(exc_valid), 32'h1);
    chk(exc_pc == first_err_pc, "R5 exc pc", exc_pc, first_err_pc);
    barrier_end();
    ack_exc();

    // R9 stray error/done signalling ignored
    new_run();
    for (int i = 0; i < 2; i++) begin
      exp_addr[i] = 32'h9000 + 32'(i); exp_data[i] = 32'(i); exp_lat[i] = 4; exp_fault[i] = 1'b0;
    end
    n_exp = 2;
    noise = 1'b1;
    push_store(32'h9000, 32'h0);
    push_store(32'h9001, 32'h1);
    barrier(cyc);
    chk(exc_valid == 1'b0, "R9 stray error ignored", 32'(exc_valid), 32'h0);
    barrier_end();
    repeat (4) @(negedge clk);
    chk(exc_valid == 1'b0, "R9 idle done ignored", 32'(exc_valid), 32'h0);
    noise = 1'b0;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule